// File: doc/BRIEF.md
# Key-Sequenced Watchdog Reset Controller

A watchdog built around a 64-bit up-counter and a 64-bit period. Software selects the watchdog mode in a global mode register, sets a sticky enable bit, and then writes two fixed key words in a set order. The first key takes the block from idle into a pre-active state. The second key takes it from pre-active into the active state. While active, the counter advances once per clock.

In the active state the block issues a single-cycle reset request in two cases: the counter reaches the period, or software writes any key word other than the two legal ones. Writing the first key and then the second key while active reloads the counter to zero, which services the watchdog. A reset request returns the controller to idle and clears the enable bit.

All access goes through a synchronous byte-addressed write port and a combinational read port.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset, every register reads zero, `rst_req_o` is low and the state code is 0 (idle).
- R2: Writes to the control word at address 0x28 have no effect unless the mode field (bits 3:2 of address 0x24) holds 2. The mode field is written through address 0x24.
- R3: The enable bit (bit 14 of 0x28) is set by writing a 1 to it. Software cannot clear it. While it is set, the mode field ignores writes.
- R4: In idle, a write to 0x28 with key 0xA5C6 in bits 31:16 moves the block to pre-active, provided the enable bit is already set or is set by the same write. In idle, any other key leaves the state unchanged and raises no reset request.
- R5: In pre-active, key 0xDA7E moves the block to active. In pre-active, any other key leaves the state unchanged and raises no reset request.
- R6: While active, the 64-bit counter (low half at 0x10, high half at 0x14) increments by one every clock, with carry into the high half. The counter and the period (low half at 0x18, high half at 0x1C) accept writes only in idle and pre-active. In the active states, writes to them are ignored.
- R7: While active, key 0xA5C6 moves the block to state code 3. Key 0xDA7E then reloads the counter to zero and returns the block to state code 2. Key 0xDA7E on its own in state 2 is accepted and changes nothing.
- R8: In either active state, a write of any key other than 0xA5C6 or 0xDA7E raises the reset request on the following cycle.
- R9: In either active state, the reset request is raised on the clock after the counter equals the period. With a zero counter and period P, the request appears P+1 cycles after arming.
- R10: The reset request is registered and lasts exactly one cycle. When it is high, the state is idle and the enable bit is clear.
- R11: Reading 0x28 returns the enable bit at bit 14 and the state code at bits 1:0 (0 idle, 1 pre-active, 2 active, 3 active with the first service key seen). All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions check the following on every cycle:
- the reset request is one cycle wide;
- the reset request coincides with the idle state;
- the reset request can only follow an active state;
- the active state is never entered straight from idle;
- the counter increments or holds as the state dictates;
- the enable bit and the mode field stay locked.

Only the bench scenarios can show the rest:
- the exact key values that advance, service or kill;
- the gating by the mode field;
- that counter writes are ignored while active;
- the exact cycle count to a timeout;
- the 32-bit carry.

The behavioural model is compared against the reset request on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 6'h10;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 6'h14;
  localparam logic [ADDR_W-1:0] ADDR_PRD_LO = 6'h18;
  localparam logic [ADDR_W-1:0] ADDR_PRD_HI = 6'h1C;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 6'h24;
  localparam logic [ADDR_W-1:0] ADDR_WDCR   = 6'h28;

  localparam int MODE_LSB = 2;
  localparam logic [1:0] MODE_WDOG = 2'd2;
  localparam int EN_BIT  = 14;
  localparam int KEY_LSB = 16;
  localparam int KEY_W   = 16;

  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PRE     = 2'd1,
    ST_ACT     = 2'd2,
    ST_ACT_ARM = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             timeout_i,
  output wd_state_e        state_o,
  output logic             active_o,
  output logic             service_o,
  output logic             fire_o,
  output logic             rst_req_o
);
  wd_state_e state_q, state_d;
  logic      req_q;

  always_comb begin
    state_d   = state_q;
    fire_o    = 1'b0;
    service_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (key_wr_i && key_i == KEY_FIRST)  state_d = ST_PRE;
      ST_PRE:  if (key_wr_i && key_i == KEY_SECOND) state_d = ST_ACT;
      ST_ACT: begin
        if (timeout_i) fire_o = 1'b1;
        else if (key_wr_i) begin
          if (key_i == KEY_FIRST)        state_d = ST_ACT_ARM;
          else if (key_i != KEY_SECOND)  fire_o  = 1'b1;
        end
      end
      ST_ACT_ARM: begin
        if (timeout_i) fire_o = 1'b1;
        else if (key_wr_i) begin
          if (key_i == KEY_SECOND) begin
            service_o = 1'b1;
            state_d   = ST_ACT;
          end else if (key_i != KEY_FIRST) fire_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fire_o) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= fire_o;
    end
  end

  assign state_o   = state_q;
  assign active_o  = (state_q == ST_ACT) || (state_q == ST_ACT_ARM);
  assign rst_req_o = req_q;

  // R10
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  // R10
  req_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> state_q == ST_IDLE);
  // R8 R9
  req_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> ($past(state_q) == ST_ACT || $past(state_q) == ST_ACT_ARM));
  // R5
  pre_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ACT |-> $past(state_q) != ST_IDLE);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int HALF_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                active_i,
  input  logic                clear_i,
  input  logic [1:0]          cnt_wr_i,
  input  logic [1:0]          prd_wr_i,
  input  logic [HALF_W-1:0]   wdata_i,
  output logic [2*HALF_W-1:0] cnt_o,
  output logic [2*HALF_W-1:0] prd_o,
  output logic                timeout_o
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] cnt_q, prd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (active_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      for (int h = 0; h < 2; h++)
        if (cnt_wr_i[h]) cnt_q[h*HALF_W +: HALF_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_q <= '0;
    end else begin
      for (int h = 0; h < 2; h++)
        if (prd_wr_i[h]) prd_q[h*HALF_W +: HALF_W] <= wdata_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign prd_o     = prd_q;
  assign timeout_o = active_i && (cnt_q == prd_q);

  // R6
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !clear_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R6
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && cnt_wr_i == 2'b00) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic [1:0]       mode_q;
  logic             en_q;
  wd_state_e        state;
  logic             active, service, fire, timeout, key_wr, wdog_mode;
  logic [1:0]       cnt_wr, prd_wr;
  logic [CNT_W-1:0] cnt, prd;

  assign wdog_mode = (mode_q == MODE_WDOG);
  assign key_wr    = wr_en_i && addr_i == ADDR_WDCR && wdog_mode
                     && (en_q || wdata_i[EN_BIT]);
  assign cnt_wr    = {2{wr_en_i && !active}} &
                     {addr_i == ADDR_CNT_HI, addr_i == ADDR_CNT_LO};
  assign prd_wr    = {2{wr_en_i && !active}} &
                     {addr_i == ADDR_PRD_HI, addr_i == ADDR_PRD_LO};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == ADDR_MODE && !en_q)
        mode_q <= wdata_i[MODE_LSB +: 2];
      if (fire)
        en_q <= 1'b0;
      else if (wr_en_i && addr_i == ADDR_WDCR && wdog_mode && wdata_i[EN_BIT])
        en_q <= 1'b1;
    end
  end

  wdog_key_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_wr_i  (key_wr),
    .key_i     (wdata_i[KEY_LSB +: KEY_W]),
    .timeout_i (timeout),
    .state_o   (state),
    .active_o  (active),
    .service_o (service),
    .fire_o    (fire),
    .rst_req_o (rst_req_o)
  );

  wdog_counter #(.HALF_W(DATA_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .clear_i   (service),
    .cnt_wr_i  (cnt_wr),
    .prd_wr_i  (prd_wr),
    .wdata_i   (wdata_i),
    .cnt_o     (cnt),
    .prd_o     (prd),
    .timeout_o (timeout)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CNT_LO: rdata_o = cnt[DATA_W-1:0];
      ADDR_CNT_HI: rdata_o = cnt[CNT_W-1:DATA_W];
      ADDR_PRD_LO: rdata_o = prd[DATA_W-1:0];
      ADDR_PRD_HI: rdata_o = prd[CNT_W-1:DATA_W];
      ADDR_MODE:   rdata_o[MODE_LSB +: 2] = mode_q;
      ADDR_WDCR: begin
        rdata_o[EN_BIT] = en_q;
        rdata_o[1:0]    = state;
      end
      default: rdata_o = '0;
    endcase
  end

  // R3
  en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !fire) |=> en_q);
  // R3
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(mode_q));
  // R10
  en_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !en_q);
endmodule

// File: tb/wdog_ctrl_tb.sv
module wdog_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  wdog_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_req_o(rst_req_o)
  );

  localparam bit [15:0] K0 = 16'hA5C6;
  localparam bit [15:0] K1 = 16'hDA7E;

  // behavioural reference model
  int              m_st;
  bit              m_en, m_req;
  int              m_mode;
  longint unsigned m_cnt, m_prd;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_en = 0; m_req = 0; m_mode = 0; m_cnt = 0; m_prd = 0;
    end else begin
      bit act, kill, keyw, svc;
      int key, nst;
      act  = (m_st >= 2);
      kill = 0; svc = 0; nst = m_st;
      key  = int'(wdata_i[31:16]);
      keyw = wr_en_i && addr_i == 6'h28 && m_mode == 2 && (m_en || wdata_i[14]);
      if (act && m_cnt == m_prd) kill = 1;
      else if (keyw) begin
        if (m_st == 0 && key == K0) nst = 1;
        else if (m_st == 1 && key == K1) nst = 2;
        else if (m_st == 2) begin
          if (key == K0) nst = 3;
          else if (key != K1) kill = 1;
        end else if (m_st == 3) begin
          if (key == K1) begin nst = 2; svc = 1; end
          else if (key != K0) kill = 1;
        end
      end
      if (kill) nst = 0;
      if (svc) m_cnt = 0;
      else if (act) m_cnt = m_cnt + 1;
      else if (wr_en_i && addr_i == 6'h10) m_cnt[31:0] = wdata_i;
      else if (wr_en_i && addr_i == 6'h14) m_cnt[63:32] = wdata_i;
      if (wr_en_i && !act && addr_i == 6'h18) m_prd[31:0] = wdata_i;
      if (wr_en_i && !act && addr_i == 6'h1C) m_prd[63:32] = wdata_i;
      if (wr_en_i && addr_i == 6'h24 && !m_en) m_mode = int'(wdata_i[3:2]);
      if (kill) m_en = 0;
      else if (wr_en_i && addr_i == 6'h28 && m_mode == 2 && wdata_i[14]) m_en = 1;
      m_st  = nst;
      m_req = kill;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the reset request against the model
  always @(negedge clk_i) if (rst_ni && !done)
    chk(rst_req_o == m_req, "R10 per-cycle rst_req", rst_req_o, m_req);

  task automatic wr(input bit [5:0] a, input bit [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd_exp(input bit [5:0] a, input bit [31:0] exp, input string tag);
    addr_i = a; #1;
    chk(rdata_o == exp, tag, rdata_o, exp);
  endtask

  task automatic rd_val(input bit [5:0] a, output bit [31:0] v);
    addr_i = a; #1; v = rdata_o;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [31:0] a, b;
    int n;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;
    @(negedge clk_i);
    rd_exp(6'h28, 32'h0, "R1 wdcr reset");
    rd_exp(6'h24, 32'h0, "R1 mode reset");
    rd_exp(6'h10, 32'h0, "R1 counter reset");
    rd_exp(6'h18, 32'h0, "R1 period reset");
    chk(rst_req_o == 0, "R1 rst_req low", rst_req_o, 0);

    wr(6'h28, {K0, 16'h4000});
    rd_exp(6'h28, 32'h0, "R2 key ignored outside wdog mode");
    wr(6'h24, 32'h8);
    rd_exp(6'h24, 32'h8, "R2 mode set");
    wr(6'h18, 32'd1000); wr(6'h1C, 32'h0);

    wr(6'h28, {16'h1234, 16'h4000});
    rd_exp(6'h28, 32'h4000, "R4 bad key in idle keeps idle");
    wr(6'h28, 32'h0);
    rd_exp(6'h28, 32'h4000, "R3 enable sticky");
    wr(6'h24, 32'h0);
    rd_exp(6'h24, 32'h8, "R3 mode locked");

    wr(6'h28, {K0, 16'h0000});
    rd_exp(6'h28, 32'h4001, "R4 first key to pre-active R11");
    wr(6'h28, {16'h0000, 16'h4000});
    rd_exp(6'h28, 32'h4001, "R5 bad key in pre-active");
    wr(6'h28, {K0, 16'h4000});
    rd_exp(6'h28, 32'h4001, "R5 first key repeated in pre-active");
    wr(6'h28, {K1, 16'h4000});
    rd_exp(6'h28, 32'h4002, "R5 second key to active");

    rd_val(6'h10, a);
    repeat (5) @(negedge clk_i);
    rd_val(6'h10, b);
    chk(b - a == 5, "R6 counter advances per clock", b - a, 5);
    wr(6'h10, 32'h0000FFFF);
    rd_exp(6'h10, 32'(m_cnt), "R6 counter write ignored while active");
    wr(6'h18, 32'd7);
    rd_exp(6'h18, 32'd1000, "R6 period write ignored while active");

    wr(6'h28, {K0, 16'h4000});
    rd_exp(6'h28, 32'h4003, "R7 service first key");
    wr(6'h28, {K1, 16'h4000});
    rd_exp(6'h28, 32'h4002, "R7 service second key");
    rd_exp(6'h10, 32'h0, "R7 counter reloaded");
    wr(6'h28, {K1, 16'h4000});
    rd_exp(6'h28, 32'h4002, "R7 lone second key harmless");

    wr(6'h28, 32'h00004000);
    chk(rst_req_o == 1, "R8 invalid key kills", rst_req_o, 1);
    rd_exp(6'h28, 32'h0, "R10 idle and enable cleared");
    @(negedge clk_i);
    chk(rst_req_o == 0, "R10 one-cycle pulse", rst_req_o, 0);

    wr(6'h10, 32'h0); wr(6'h14, 32'h0); wr(6'h18, 32'd20);
    wr(6'h28, {K0, 16'h4000});
    wr(6'h28, {K1, 16'h4000});
    n = 0;
    while (!rst_req_o && n < 100) begin
      @(negedge clk_i);
      n++;
    end
    chk(n == 21, "R9 timeout cycle count", n, 21);

    wr(6'h10, 32'hFFFF_FFFE); wr(6'h14, 32'h0);
    wr(6'h18, 32'h0); wr(6'h1C, 32'h5);
    wr(6'h28, {K0, 16'h4000});
    wr(6'h28, {K1, 16'h4000});
    repeat (3) @(negedge clk_i);
    rd_exp(6'h14, 32'h1, "R6 carry into high half");
    rd_exp(6'h10, 32'h1, "R6 low half after carry");

    wr(6'h28, {K0, 16'h4000});
    rd_exp(6'h28, 32'h4003, "R7 first key seen");
    wr(6'h28, {16'hBEEF, 16'h4000});
    chk(rst_req_o == 1, "R8 invalid key in state 3 kills", rst_req_o, 1);
    @(negedge clk_i);
    rd_exp(6'h28, 32'h0, "R10 back to idle R11");

    repeat (2) @(negedge clk_i);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule